// File: doc/BRIEF.md
# Printer Port Host Register File

This block is the host-facing register set of a standard byte-wide printer port. It also contains a small emulated printer that answers the host's handshake. The host reaches three registers through a 3-bit offset: an output data byte, a printer status byte and a port control byte. Reads are combinational. Writes take effect on the clock edge where the write enable is high.

There is no timed cable. The emulated printer advances only on host activity. A control write that raises the strobe bit, with init and select-in high, hands the stored output byte to the output port as a one-cycle valid pulse and marks the printer busy. Each later status read walks the printer through its acknowledge and ready steps.

A control write that leaves strobe low can raise a pending-interrupt flag, provided interrupts were already enabled. That flag drives a level interrupt output, and the next status read clears it. When the direction bit selects input, a data read returns the byte last captured from an external input port.

Top module: `pport_host_regs`

## Requirements
- R1: Offset 0 is data, 1 is status and 2 is control. Offsets 3 to 7 read 0xFF. A write to offset 1 or to offsets 3 to 7 changes no register.
- R2: After reset the output and input data latches hold 0xFF, status reads 0xD9, control reads 0xCC, and irq and out_valid are low.
- R3: A control write stores the written byte with bits 7:6 forced to 1. The control bits are: 5 direction (1 = input), 4 interrupt enable, 3 select-in, 2 init, 1 auto-feed, 0 strobe.
- R4: A control write with init (bit 2) equal to 0 sets status to 0xD8. The status bits are: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 not-error, 0 timeout.
- R5: A control write with init, select-in and strobe all 1 clears status bit 7. If the stored strobe bit was 0 before the write, out_valid is high for exactly the one cycle after the write edge, and out_data then holds the output data latch.
- R6: A control write with init 1, select-in 1 and strobe 0 sets the pending-interrupt flag when the stored interrupt-enable bit was 1 before the write.
- R7: A status read returns the current status and clears the pending-interrupt flag.
- R8: A status read made while status bit 7 is 0 and the stored strobe bit is 0 then updates status. If bit 6 is 1, it clears bit 6. Otherwise it sets bits 6 and 7.
- R9: A data read returns the input latch when control bit 5 is 1, and the output latch when it is 0.
- R10: A data write loads the output latch. In a cycle with in_valid high, in_data loads the input latch.
- R11: bus_rdata shows the addressed register in the same cycle. irq is high exactly while the pending-interrupt flag is set, starting the cycle after the write that sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write enable, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe; it triggers the status-read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_data | output | 8 | Emitted byte |
| in_valid | input | 1 | Input latch load enable |
| in_data | input | 8 | Input latch data |

## Verification
All 256 control byte values are swept in turn, each after a fresh data write and followed by a status read. A bench-side model predicts every readback, every emission and the interrupt level.

Directed cases cover the following traps:
- A second strobe-high write with no falling strobe between must not emit the byte again.
- An interrupt must depend on the enable bit already stored, not on the enable bit being written.
- A status read must step through busy, acknowledge-clear and ready in that order.
- A status write must not clear a bit.
- A reversed data direction must return the captured input byte, not the output byte.

A design that emitted on every strobe-high write would show a pulse where none is due. One that used the new enable bit would raise irq one write early. A stepping order error would show as a wrong status byte on the second or third read.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned PP_AW = 3;
  localparam int unsigned PP_DW = 8;

  localparam logic [PP_AW-1:0] OFS_DATA = 3'd0;
  localparam logic [PP_AW-1:0] OFS_STAT = 3'd1;
  localparam logic [PP_AW-1:0] OFS_CTRL = 3'd2;

  localparam int unsigned ST_NBUSY  = 7;
  localparam int unsigned ST_ACK    = 6;
  localparam int unsigned ST_PAPER  = 5;
  localparam int unsigned ST_ONLINE = 4;
  localparam int unsigned ST_NERR   = 3;
  localparam int unsigned ST_TMO    = 0;

  localparam int unsigned CT_DIR   = 5;
  localparam int unsigned CT_IRQEN = 4;
  localparam int unsigned CT_SELIN = 3;
  localparam int unsigned CT_INIT  = 2;
  localparam int unsigned CT_AFD   = 1;
  localparam int unsigned CT_STB   = 0;

  localparam logic [PP_DW-1:0] ST_RESET   = 8'hD9;
  localparam logic [PP_DW-1:0] ST_INITVAL = 8'hD8;
  localparam logic [PP_DW-1:0] CT_RESET   = 8'hCC;
  localparam logic [PP_DW-1:0] CT_FORCE   = 8'hC0;
  localparam logic [PP_DW-1:0] DATA_RESET = 8'hFF;
  localparam logic [PP_DW-1:0] RD_OPEN    = 8'hFF;
endpackage

// File: rtl/pport_ctl_unit.sv
module pport_ctl_unit
  import pport_pkg::*;
#(
  parameter int unsigned DW = PP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          rd_stat,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic          pend_q,
  output logic          emit
);
  logic [DW-1:0] ctrl_d, stat_d, wval;
  logic          pend_d, upd_en;

  assign wval   = wdata | CT_FORCE;
  assign upd_en = wr_ctrl | rd_stat;

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    pend_d = pend_q;
    emit   = 1'b0;
    if (wr_ctrl) begin
      ctrl_d = wval;
      if (!wval[CT_INIT]) begin
        stat_d = ST_INITVAL;
      end else if (wval[CT_SELIN]) begin
        if (wval[CT_STB]) begin
          stat_d[ST_NBUSY] = 1'b0;
          emit = !ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IRQEN]) begin
          pend_d = 1'b1;
        end
      end
    end else if (rd_stat) begin
      pend_d = 1'b0;
      if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_d[ST_ACK] = 1'b0;
        end else begin
          stat_d[ST_ACK]   = 1'b1;
          stat_d[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CT_RESET;
      stat_q <= ST_RESET;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  // R3: stored control always carries ones in its top two bits
  p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q[7:6] == 2'b11));
  // R4
  p_init_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CT_INIT]) |=> (stat_q == ST_INITVAL));
  // R5: strobe write leaves the printer busy
  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CT_INIT] && wdata[CT_SELIN] && wdata[CT_STB]) |=> !stat_q[ST_NBUSY]);
  // R5: after an emission the stored strobe is high
  p_emit_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> ctrl_q[CT_STB]);
  // R6
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CT_INIT] && wdata[CT_SELIN] && !wdata[CT_STB] && ctrl_q[CT_IRQEN])
      |=> pend_q);
  // R7
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !pend_q);
  // R8: acknowledge falls first, busy stays
  p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !stat_q[ST_NBUSY] && !ctrl_q[CT_STB] && stat_q[ST_ACK])
      |=> (!stat_q[ST_ACK] && !stat_q[ST_NBUSY]));
  // R8: then ready returns with acknowledge
  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !stat_q[ST_NBUSY] && !ctrl_q[CT_STB] && !stat_q[ST_ACK])
      |=> (stat_q[ST_ACK] && stat_q[ST_NBUSY]));
endmodule

// File: rtl/pport_data_unit.sv
module pport_data_unit
  import pport_pkg::*;
#(
  parameter int unsigned DW = PP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          emit,
  input  logic          dir_in,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] dout_q, din_q, od_q;
  logic          ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= DATA_RESET;
    end else if (wr_data) begin
      dout_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= DATA_RESET;
    end else if (in_valid) begin
      din_q <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= DATA_RESET;
    end else begin
      ov_q <= emit;
      if (emit) begin
        od_q <= dout_q;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign rd_word   = dir_in ? din_q : dout_q;

  // R5: each emission lasts one cycle
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R10
  p_in_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (din_q == $past(in_data)));
  // R5: emitted byte is the output latch
  p_emit_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !wr_data) |=> (out_valid && out_data == dout_q));
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int unsigned AW = PP_AW,
  parameter int unsigned DW = PP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data
);
  logic          wr_ctrl, wr_data, rd_stat, emit, pend_q;
  logic [DW-1:0] ctrl_q, stat_q, data_word;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign rd_stat = bus_rd && !bus_wr && (bus_addr == OFS_STAT);

  pport_ctl_unit #(.DW(DW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .rd_stat (rd_stat),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q),
    .pend_q  (pend_q),
    .emit    (emit)
  );

  pport_data_unit #(.DW(DW)) u_dat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wdata     (bus_wdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .emit      (emit),
    .dir_in    (ctrl_q[CT_DIR]),
    .out_valid (out_valid),
    .out_data  (out_data),
    .rd_word   (data_word)
  );

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = data_word;
      OFS_STAT: bus_rdata = stat_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = RD_OPEN;
    endcase
  end

  assign irq = pend_q;

  // R1: writes elsewhere leave control untouched
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_CTRL) |=> $stable(ctrl_q));
  // R11: irq only rises after a control write
  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_ctrl));
endmodule

// File: tb/tb_pport_host_regs.sv
module tb_pport_host_regs;
  logic       clk, rst_n, bus_wr, bus_rd, in_valid, irq, out_valid;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, out_data, in_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_st, m_ct, m_dout, m_din;
  logic       m_pend;

  pport_host_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .out_valid(out_valid), .out_data(out_data),
    .in_valid(in_valid), .in_data(in_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] wv;
    logic       exp_emit;
    logic [7:0] exp_byte;
    exp_emit = 1'b0;
    exp_byte = m_dout;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    if (a == 3'd0) m_dout = d;
    else if (a == 3'd2) begin
      wv = d | 8'hC0;
      if (!wv[2]) m_st = 8'hD8;
      else if (wv[3]) begin
        if (wv[0]) begin m_st[7] = 1'b0; exp_emit = !m_ct[0]; end
        else if (m_ct[4]) m_pend = 1'b1;
      end
      m_ct = wv;
    end
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R5 out_valid", {7'b0, out_valid}, {7'b0, exp_emit});
    if (exp_emit) chk("R5 out_data", out_data, exp_byte);
    chk("R6/R11 irq", {7'b0, irq}, {7'b0, m_pend});
    if (exp_emit) begin
      @(negedge clk);
      chk("R5 single pulse", {7'b0, out_valid}, 8'h00);
    end
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    case (a)
      3'd0: exp = m_ct[5] ? m_din : m_dout;
      3'd1: exp = m_st;
      3'd2: exp = m_ct;
      default: exp = 8'hFF;
    endcase
    #1;
    chk(tag, bus_rdata, exp);
    if (a == 3'd1) begin
      m_pend = 1'b0;
      if (!m_st[7] && !m_ct[0]) begin
        if (m_st[6]) m_st[6] = 1'b0;
        else begin m_st[6] = 1'b1; m_st[7] = 1'b1; end
      end
    end
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R7/R11 irq after read", {7'b0, irq}, {7'b0, m_pend});
  endtask

  task automatic feed_in(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    m_din = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd0;
    bus_wdata = 8'h00; in_valid = 1'b0; in_data = 8'h00;
    m_st = 8'hD9; m_ct = 8'hCC; m_dout = 8'hFF; m_din = 8'hFF; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 irq reset", {7'b0, irq}, 8'h00);
    chk("R2 out_valid reset", {7'b0, out_valid}, 8'h00);
    do_read(3'd2, "R2 control reset");
    do_read(3'd0, "R2 data reset");
    do_read(3'd1, "R2 status reset");

    // R1: unmapped offsets read open, writes to them change nothing
    for (int a = 3; a < 8; a++) do_read(3'(a), "R1 unmapped read");
    for (int a = 3; a < 8; a++) do_write(3'(a), 8'h00);
    do_write(3'd1, 8'h00);
    do_read(3'd1, "R1 status write ignored");
    do_read(3'd2, "R1 control unchanged");
    do_read(3'd0, "R1 data unchanged");

    // R10/R11: data write visible on the very next cycle
    do_write(3'd0, 8'hA5);
    do_read(3'd0, "R11 data readback");

    // R5 handshake: strobe low, then high, then repeated high
    do_write(3'd2, 8'h0C);
    do_write(3'd2, 8'h0D);
    do_read(3'd1, "R5 busy after strobe");
    do_write(3'd2, 8'h0D);
    do_write(3'd2, 8'h0C);
    // R8 stepping: busy+ack -> ack clear -> ready
    do_read(3'd1, "R8 step one");
    do_read(3'd1, "R8 step two");
    do_read(3'd1, "R8 step three");

    // R6: enable written first, then strobe-low write raises irq
    do_write(3'd2, 8'h1C);
    do_write(3'd2, 8'h1C);
    do_read(3'd1, "R7 status read clears irq");

    // R4
    do_write(3'd2, 8'h18);
    do_read(3'd1, "R4 init status");

    // R9/R10 input direction
    feed_in(8'h3C);
    do_write(3'd2, 8'h2C);
    do_read(3'd0, "R9 input latch");
    do_write(3'd2, 8'h0C);
    do_read(3'd0, "R9 output latch");

    // R3 and full sweep of every control value
    for (int v = 0; v < 256; v++) begin
      do_write(3'd0, 8'(v) ^ 8'h5A);
      do_write(3'd2, 8'(v));
      do_read(3'd2, "R3 control readback");
      do_read(3'd1, "R8 sweep status");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule